// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. Both directions share one programmable divider of the system clock. The divider produces an oversampling tick, and each bit lasts a fixed number of ticks. Frame settings, line-control requests and modem-line requests reach the block as plain register bits. Characters pass through a single-strobe write port on the transmit side and a read-acknowledge port on the receive side.

Each character carries 6, 7 or 8 data bits and may be followed by one extra bit. That extra bit is either a parity bit with a selectable rule or, in multidrop mode, an address marker. The receiver checks that each start bit is real. It reports parity, framing and overrun errors on three separate sticky flags. A line held low for a whole frame is reported as a break and is not delivered as a character. The transmitter can force the line low to send a break.

A channel-mode selector routes the serial pins in one of four ways: normal, automatic echo, local loopback and remote loopback. Two modem request outputs are active low. Four modem status inputs pass through a two-flop synchroniser before they are visible.

Top module: `mdrop_usart`

## Requirements
- R1: One bit lasts OVS x baud_div clock cycles (OVS = 16 by default). The first bit of a transmitted frame may be up to one tick shorter, because it starts from the free-running tick.
- R2: A transmitted frame is sent in this order: a 0 start bit, the data bits LSB first, the extra bit when one is enabled, and a 1 stop bit. char_len codes are 0 = 6 bits, 1 = 7 bits, 2 or 3 = 8 bits. tx_ready is low while a frame is in progress, and a tx_wr in that time is ignored.
- R3: par_mode codes are 0 = none, 1 = even (extra bit = XOR of the data bits), 2 = odd (its inverse), 3 = always 0, 4 = always 1, and 5 to 7 = none. The transmitter appends the bit its rule gives. The receiver raises par_err when a received extra bit differs from that rule.
- R4: A received character appears on rx_data with rx_valid high. Unused upper data bits read as 0. An rx_rd pulse clears rx_valid.
- R5: A low pulse on the receive line shorter than half a bit is not taken as a start bit, and no character or flag results.
- R6: A stop bit received as 0 sets frm_err. The character is still delivered, unless the frame is a break.
- R7: When a character completes while rx_valid is still high and not being read, ovr_err is set and rx_data takes the new character.
- R8: A frame whose data bits, extra bit and stop bit are all 0 sets brk_det and delivers no character. brk_det stays high until the receive line is seen high again.
- R9: While brk_req is high, the internal transmit line is driven low.
- R10: With mdrop_en high, the extra bit is always present and ignores par_mode. On transmit it carries tx_addr. On receive it shows on rx_addr and causes no parity error.
- R11: chan_mode codes are 0 = normal, 1 = automatic echo, 2 = local loopback and 3 = remote loopback. In echo, txd repeats rxd two clocks later while the receiver also takes rxd. In local loopback, txd stays 1 and the receiver takes the internal transmit line. In remote loopback, txd repeats rxd two clocks later and the receiver sees an idle line.
- R12: rts_n and dtr_n are the inverses of rts_on and dtr_on. modem_st[3:0] = {cts, dsr, dcd, ri} holds the inverted pins cts_n, dsr_n, dcd_n and ri_n, visible two clocks after a pin changes. After reset the flags and modem_st are 0 and txd is 1.
- R13: err_clr clears par_err, frm_err and ovr_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | DIV_W | Clock cycles per oversampling tick (0 acts as 1) |
| char_len | input | 2 | Data length code |
| par_mode | input | 3 | Extra-bit rule code |
| chan_mode | input | 2 | Pin routing code |
| mdrop_en | input | 1 | Multidrop address-marking mode |
| tx_wr | input | 1 | Write strobe for one character |
| tx_data | input | 8 | Character to send |
| tx_addr | input | 1 | Address marker sent in multidrop mode |
| brk_req | input | 1 | Hold the transmit line low |
| tx_ready | output | 1 | Transmitter can take a character |
| rx_rd | input | 1 | Acknowledge the received character |
| err_clr | input | 1 | Clear the sticky error flags |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | An unread character is held |
| rx_addr | output | 1 | Received address marker |
| par_err | output | 1 | Parity mismatch seen |
| frm_err | output | 1 | Missing stop bit seen |
| ovr_err | output | 1 | Unread character overwritten |
| brk_det | output | 1 | Break on the receive line |
| rts_on | input | 1 | Request-to-send register bit |
| dtr_on | input | 1 | Terminal-ready register bit |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Set-ready pin, active low |
| dcd_n | input | 1 | Carrier pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| modem_st | output | 4 | Synchronised modem status, active high |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |

## Verification
Each result is sampled where its latency puts it:
- Modem status bits and the looped-back txd in echo and remote modes are due exactly two clocks after the pin changes. The bench checks modem_st one clock early (still old) and on the due clock (new), and compares txd against a two-deep history of rxd on every clock.
- Transmitted bits are sampled half a bit after the observed falling edge and then once per bit period. This keeps each sample clear of the up-to-one-tick stretch of the start bit.
- Receive results become due at the middle of the stop bit plus the synchroniser delay. The bench therefore reads rx_data and the flags only after the whole stop bit has been driven.
- For a break, brk_det is read while the line is still low and again one bit time after release.

// File: rtl/usart_pkg.sv
package usart_pkg;

   typedef enum logic [1:0] {
      CH_NORMAL = 2'd0,
      CH_ECHO   = 2'd1,
      CH_LOCAL  = 2'd2,
      CH_REMOTE = 2'd3
   } chan_e;

   // data bit count from the length code: 0 -> 6, 1 -> 7, others -> 8
   function automatic logic [3:0] data_bits(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd6;
         2'd1:    return 4'd7;
         default: return 4'd8;
      endcase
   endfunction

   function automatic logic [7:0] len_mask(input logic [3:0] nd);
      logic [8:0] m;
      m = (9'd1 << nd) - 9'd1;
      return m[7:0];
   endfunction

   function automatic logic has_par(input logic [2:0] pm);
      return (pm >= 3'd1) && (pm <= 3'd4);
   endfunction

   // extra bit value for already masked data
   function automatic logic par_bit(input logic [2:0] pm, input logic [7:0] d);
      case (pm)
         3'd1:    return ^d;
         3'd2:    return ~^d;
         3'd4:    return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/usart_baud.sv
module usart_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (cnt == '0)
         cnt <= (div == '0) ? '0 : div - 1'b1;
      else
         cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/usart_sync.sv
module usart_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/usart_tx.sv
module usart_tx
   import usart_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       waddr,
   input  logic [1:0] char_len,
   input  logic [2:0] par_mode,
   input  logic       mdrop,
   input  logic       brk_req,
   output logic       ready,
   output logic       line
);
   localparam int SW     = $clog2(OVS);
   localparam int FRAME  = 11;

   logic             busy;
   logic [FRAME-1:0] sr, fr;
   logic [3:0]       rem, nd;
   logic [SW-1:0]    sub;
   logic [7:0]       md;
   logic             ext, eb;

   always_comb begin
      nd  = data_bits(char_len);
      md  = wdata & len_mask(nd);
      ext = mdrop | has_par(par_mode);
      eb  = mdrop ? waddr : par_bit(par_mode, md);
      fr  = '1;
      fr[0] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (4'(i) < nd) fr[1+i] = wdata[i];
      if (ext) fr[1+nd] = eb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sr   <= '1;
         rem  <= '0;
         sub  <= '0;
      end else if (!busy) begin
         if (wr) begin
            busy <= 1'b1;
            sr   <= fr;
            rem  <= 4'd2 + nd + {3'b0, ext};
            sub  <= '0;
         end
      end else if (tick) begin
         if (sub == SW'(OVS-1)) begin
            sub <= '0;
            sr  <= {1'b1, sr[FRAME-1:1]};
            rem <= rem - 4'd1;
            if (rem == 4'd1) busy <= 1'b0;
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end

   assign ready = !busy;
   assign line  = brk_req ? 1'b0 : (busy ? sr[0] : 1'b1);

   // R2: a frame opens on a low start bit and its last bit is a high stop bit
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !sr[0]);
   a_r2_stop_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(sr[0]));
endmodule

// File: rtl/usart_rx.sv
module usart_rx
   import usart_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line,
   input  logic [1:0] char_len,
   input  logic [2:0] par_mode,
   input  logic       mdrop,
   input  logic       rd,
   input  logic       err_clr,
   output logic [7:0] data,
   output logic       valid,
   output logic       addr,
   output logic       perr,
   output logic       frm,
   output logic       ovr,
   output logic       brk
);
   localparam int SW  = $clog2(OVS);
   localparam int MID = OVS / 2;

   typedef enum logic [2:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_HOLD} rx_st_e;

   rx_st_e        st;
   logic [8:0]    rbuf;
   logic [3:0]    idx, nd, nx;
   logic [SW-1:0] sub;
   logic          ext;
   logic [7:0]    md;

   always_comb begin
      nd  = data_bits(char_len);
      ext = mdrop | has_par(par_mode);
      nx  = nd + {3'b0, ext};
      md  = rbuf[7:0] & len_mask(nd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RX_IDLE; rbuf <= '0; idx <= '0; sub <= '0;
         data <= '0; valid <= 1'b0; addr <= 1'b0;
         perr <= 1'b0; frm <= 1'b0; ovr <= 1'b0; brk <= 1'b0;
      end else begin
         if (err_clr) begin
            perr <= 1'b0; frm <= 1'b0; ovr <= 1'b0;
         end
         if (rd) valid <= 1'b0;
         if (tick) begin
            case (st)
               RX_IDLE: if (!line) begin
                  st  <= RX_START;
                  sub <= '0;
               end
               RX_START: if (sub == SW'(MID-1)) begin
                  st   <= line ? RX_IDLE : RX_BITS;
                  sub  <= '0;
                  idx  <= '0;
                  rbuf <= '0;
               end else sub <= sub + 1'b1;
               RX_BITS: if (sub == SW'(OVS-1)) begin
                  sub       <= '0;
                  rbuf[idx] <= line;
                  if (idx == nx - 4'd1) st <= RX_STOP;
                  else idx <= idx + 4'd1;
               end else sub <= sub + 1'b1;
               RX_STOP: if (sub == SW'(OVS-1)) begin
                  sub <= '0;
                  if (!line && rbuf == '0) begin
                     brk <= 1'b1;
                     st  <= RX_HOLD;
                  end else begin
                     st    <= RX_IDLE;
                     data  <= md;
                     addr  <= mdrop & rbuf[nd];
                     valid <= 1'b1;
                     if (valid && !rd) ovr <= 1'b1;
                     if (!line) frm <= 1'b1;
                     if (!mdrop && has_par(par_mode) && rbuf[nd] != par_bit(par_mode, md))
                        perr <= 1'b1;
                  end
               end else sub <= sub + 1'b1;
               default: if (line) begin
                  brk <= 1'b0;
                  st  <= RX_IDLE;
               end
            endcase
         end
      end
   end

   // R3: a parity error comes with a delivered character
   a_r3_perr_with_char: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(perr) |-> valid);
   // R6: framing error stays until cleared
   a_r6_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      frm && !err_clr |=> frm);
   // R7: overrun only when an unread character was held
   a_r7_ovr_needs_unread: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(valid));
   // R8: break flag drops only after the line was seen high
   a_r8_brk_ends_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brk) |-> $past(line));
endmodule

// File: rtl/mdrop_usart.sv
module mdrop_usart
   import usart_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] baud_div,
   input  logic [1:0]       char_len,
   input  logic [2:0]       par_mode,
   input  logic [1:0]       chan_mode,
   input  logic             mdrop_en,
   input  logic             tx_wr,
   input  logic [7:0]       tx_data,
   input  logic             tx_addr,
   input  logic             brk_req,
   output logic             tx_ready,
   input  logic             rx_rd,
   input  logic             err_clr,
   output logic [7:0]       rx_data,
   output logic             rx_valid,
   output logic             rx_addr,
   output logic             par_err,
   output logic             frm_err,
   output logic             ovr_err,
   output logic             brk_det,
   input  logic             rts_on,
   input  logic             dtr_on,
   output logic             rts_n,
   output logic             dtr_n,
   input  logic             cts_n,
   input  logic             dsr_n,
   input  logic             dcd_n,
   input  logic             ri_n,
   output logic [3:0]       modem_st,
   input  logic             rxd,
   output logic             txd
);
   localparam int MODEM_W = 4;
   localparam int SYNC_W  = MODEM_W + 1;

   if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be positive");
   end

   logic              tick, tx_line, rx_line, rxs;
   logic [SYNC_W-1:0] sync_q;
   chan_e             chan;

   assign chan = chan_e'(chan_mode);

   usart_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div(baud_div), .tick(tick));

   usart_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL({SYNC_W{1'b1}})) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({rxd, cts_n, dsr_n, dcd_n, ri_n}), .q(sync_q));

   assign rxs      = sync_q[SYNC_W-1];
   assign modem_st = ~sync_q[MODEM_W-1:0];
   assign rts_n    = ~rts_on;
   assign dtr_n    = ~dtr_on;

   always_comb begin
      case (chan)
         CH_ECHO:   begin txd = rxs;     rx_line = rxs;     end
         CH_LOCAL:  begin txd = 1'b1;    rx_line = tx_line; end
         CH_REMOTE: begin txd = rxs;     rx_line = 1'b1;    end
         default:   begin txd = tx_line; rx_line = rxs;     end
      endcase
   end

   usart_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr(tx_wr), .wdata(tx_data),
      .waddr(tx_addr), .char_len(char_len), .par_mode(par_mode),
      .mdrop(mdrop_en), .brk_req(brk_req), .ready(tx_ready), .line(tx_line));

   usart_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line(rx_line),
      .char_len(char_len), .par_mode(par_mode), .mdrop(mdrop_en),
      .rd(rx_rd), .err_clr(err_clr), .data(rx_data), .valid(rx_valid),
      .addr(rx_addr), .perr(par_err), .frm(frm_err), .ovr(ovr_err),
      .brk(brk_det));
endmodule

// File: tb/mdrop_usart_test.sv
`timescale 1ns/1ps
module mdrop_usart_test;
   localparam int DIV = 2;
   localparam int BIT = 16 * DIV;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [15:0] baud_div = 16'(DIV);
   logic [1:0] char_len = 2'd2, chan_mode = 2'd0;
   logic [2:0] par_mode = 3'd0;
   logic       mdrop_en = 0, tx_wr = 0, tx_addr = 0, brk_req = 0;
   logic [7:0] tx_data = 0;
   logic       rx_rd = 0, err_clr = 0, rts_on = 0, dtr_on = 0;
   logic       cts_n = 1, dsr_n = 1, dcd_n = 1, ri_n = 1, rxd = 1;
   logic       tx_ready, rx_valid, rx_addr, par_err, frm_err, ovr_err, brk_det;
   logic       rts_n, dtr_n, txd;
   logic [7:0] rx_data;
   logic [3:0] modem_st;

   int compared = 0, mismatched = 0, cyc = 0;
   bit done = 0, cmp_on = 0;
   logic ha = 1, hb = 1;
   logic [11:0] fr;
   int fn;

   always #2 clk = ~clk;

   mdrop_usart uut (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         compared++; mismatched++;
         $display("FAIL watchdog: actual %0d expected below 150000", cyc);
         summary();
         $finish;
      end
   end

   // two-clock history of the receive pin for the looped-back txd
   always @(posedge clk) begin
      hb <= ha;
      ha <= rxd;
   end
   always @(negedge clk)
      if (cmp_on) chk(txd === hb, "R11 looped txd", txd, hb);

   function automatic bit pbit(input logic [7:0] d, input int nd, input int mode);
      int ones = 0;
      for (int i = 0; i < nd; i++) ones += d[i];
      case (mode)
         1: return ones % 2;
         2: return !(ones % 2);
         4: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic build(input logic [7:0] d, input int nd, input int ext, input bit eb, input bit stp);
      fr = '1;
      fr[0] = 1'b0;
      for (int i = 0; i < nd; i++) fr[1+i] = d[i];
      if (ext != 0) fr[1+nd] = eb;
      fr[1+nd+ext] = stp;
      fn = 2 + nd + ext;
   endtask

   task automatic rx_send();
      for (int k = 0; k < fn; k++) begin
         rxd = fr[k];
         repeat (BIT) @(negedge clk);
      end
      rxd = 1'b1;
   endtask

   task automatic pulse_rd();
      rx_rd = 1; @(negedge clk); rx_rd = 0; @(negedge clk);
   endtask

   task automatic pulse_clr();
      err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
   endtask

   task automatic tx_check(input logic [7:0] d, input logic a, input bit poke, input string req);
      int lows = 0;
      @(negedge clk); tx_data = d; tx_addr = a; tx_wr = 1;
      @(negedge clk); tx_wr = 0;
      for (int c = 0; c < BIT * fn + 4; c++) begin
         if (c == 2 && poke) begin
            chk(tx_ready == 0, "R2 busy", tx_ready, 0);
            tx_data = ~d; tx_wr = 1;
         end
         if (c == 3) tx_wr = 0;
         if ((c % BIT) == BIT / 2) chk(txd == fr[c/BIT], req, txd, fr[c/BIT]);
         @(negedge clk);
      end
      for (int c = 0; c < 2 * BIT; c++) begin
         if (!txd) lows++;
         @(negedge clk);
      end
      chk(lows == 0 && tx_ready, "R2 idle after frame", lows, 0);
   endtask

   initial begin
      int lows;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state (R12)
      chk(txd == 1 && tx_ready == 1, "R12 reset tx", {txd, tx_ready}, 3);
      chk({rx_valid, par_err, frm_err, ovr_err, brk_det} == 0, "R12 reset flags",
          {rx_valid, par_err, frm_err, ovr_err, brk_det}, 0);
      chk(rts_n && dtr_n && modem_st == 0, "R12 reset modem", {rts_n, dtr_n, modem_st}, 6'h30);

      // R2 8-bit, no parity, write while busy ignored
      build(8'hA5, 8, 0, 0, 1);
      tx_check(8'hA5, 0, 1, "R2 tx bit");

      // R1 bit time: 0x00 keeps line low for start + 8 bits
      @(negedge clk); tx_data = 8'h00; tx_wr = 1;
      @(negedge clk); tx_wr = 0;
      lows = 0;
      while (txd == 0 && lows < 1000) begin lows++; @(negedge clk); end
      chk(lows >= 9 * BIT - 1 && lows <= 9 * BIT, "R1 low span", lows, 9 * BIT);
      repeat (3 * BIT) @(negedge clk);

      // R3 parity rules on transmit
      char_len = 2'd1; par_mode = 3'd1;
      build(8'h53, 7, 1, pbit(8'h53, 7, 1), 1);
      tx_check(8'h53, 0, 0, "R3 even tx");
      char_len = 2'd0; par_mode = 3'd2;
      build(8'h2D, 6, 1, pbit(8'h2D, 6, 2), 1);
      tx_check(8'h2D, 0, 0, "R3 odd tx");
      char_len = 2'd2; par_mode = 3'd4;
      build(8'h00, 8, 1, 1, 1);
      tx_check(8'h00, 0, 0, "R3 force1 tx");
      par_mode = 3'd3;
      build(8'hFF, 8, 1, 0, 1);
      tx_check(8'hFF, 0, 0, "R3 force0 tx");

      // R10 multidrop transmit of an address character
      par_mode = 3'd1; mdrop_en = 1;
      build(8'h42, 8, 1, 1, 1);
      tx_check(8'h42, 1, 0, "R10 addr tx");
      mdrop_en = 0; par_mode = 3'd0;

      // R4 receive and read
      build(8'h3C, 8, 0, 0, 1); rx_send();
      chk(rx_valid && rx_data == 8'h3C, "R4 rx data", rx_data, 8'h3C);
      chk({par_err, frm_err, ovr_err} == 0, "R4 no flags", {par_err, frm_err, ovr_err}, 0);
      pulse_rd();
      chk(rx_valid == 0, "R4 read clears", rx_valid, 0);
      char_len = 2'd0;
      build(8'h15, 6, 0, 0, 1); rx_send();
      chk(rx_valid && rx_data == 8'h15, "R4 6-bit rx", rx_data, 8'h15);
      pulse_rd(); char_len = 2'd2;

      // R3 parity check on receive, R13 clear
      par_mode = 3'd1;
      build(8'h07, 8, 1, pbit(8'h07, 8, 1), 1); rx_send();
      chk(rx_valid && !par_err, "R3 good parity", par_err, 0);
      pulse_rd();
      build(8'h07, 8, 1, !pbit(8'h07, 8, 1), 1); rx_send();
      chk(par_err == 1, "R3 bad parity", par_err, 1);
      pulse_rd(); pulse_clr();
      chk(par_err == 0, "R13 clear", par_err, 0);
      par_mode = 3'd0;

      // R6 framing error
      build(8'h81, 8, 0, 0, 0); rx_send();
      repeat (BIT) @(negedge clk);
      chk(frm_err && rx_valid && rx_data == 8'h81, "R6 framing", {frm_err, rx_data}, 9'h181);
      pulse_rd(); pulse_clr();
      chk(frm_err == 0, "R13 frm clear", frm_err, 0);

      // R7 overrun
      build(8'h11, 8, 0, 0, 1); rx_send();
      build(8'h22, 8, 0, 0, 1); rx_send();
      chk(ovr_err && rx_data == 8'h22, "R7 overrun", {ovr_err, rx_data}, 9'h122);
      pulse_rd(); pulse_clr();

      // R5 short glitch
      rxd = 0; repeat (6) @(negedge clk); rxd = 1;
      repeat (12 * BIT) @(negedge clk);
      chk({rx_valid, frm_err, brk_det} == 0, "R5 glitch", {rx_valid, frm_err, brk_det}, 0);

      // R8 break
      rxd = 0; repeat (13 * BIT) @(negedge clk);
      chk(brk_det == 1, "R8 break set", brk_det, 1);
      chk(rx_valid == 0 && frm_err == 0, "R8 no char", {rx_valid, frm_err}, 0);
      repeat (BIT) @(negedge clk);
      rxd = 1; repeat (BIT) @(negedge clk);
      chk(brk_det == 0 && rx_valid == 0, "R8 break clear", {brk_det, rx_valid}, 0);

      // R10 multidrop receive, parity rule ignored
      mdrop_en = 1; par_mode = 3'd1;
      build(8'h42, 8, 1, 1, 1); rx_send();
      chk(rx_valid && rx_addr && !par_err, "R10 addr rx", {rx_addr, par_err}, 2);
      pulse_rd();
      build(8'h43, 8, 1, 0, 1); rx_send();
      chk(rx_valid && !rx_addr && rx_data == 8'h43, "R10 data rx", {rx_addr, rx_data}, 8'h43);
      pulse_rd(); mdrop_en = 0; par_mode = 3'd0;

      // R9 transmit break
      brk_req = 1; @(negedge clk);
      chk(txd == 0, "R9 break low", txd, 0);
      brk_req = 0; @(negedge clk);
      chk(txd == 1, "R9 break released", txd, 1);

      // R11 local loopback
      chan_mode = 2'd2; repeat (3) @(negedge clk);
      @(negedge clk); tx_data = 8'h5A; tx_wr = 1;
      @(negedge clk); tx_wr = 0;
      lows = 0;
      for (int c = 0; c < 12 * BIT; c++) begin
         if (!txd) lows++;
         @(negedge clk);
      end
      chk(lows == 0, "R11 local pin idle", lows, 0);
      chk(rx_valid && rx_data == 8'h5A, "R11 local rx", rx_data, 8'h5A);
      pulse_rd();

      // R11 automatic echo
      chan_mode = 2'd1; repeat (4) @(negedge clk);
      cmp_on = 1;
      build(8'h96, 8, 0, 0, 1); rx_send();
      repeat (4) @(negedge clk);
      cmp_on = 0;
      chk(rx_valid && rx_data == 8'h96, "R11 echo rx", rx_data, 8'h96);
      pulse_rd();

      // R11 remote loopback
      chan_mode = 2'd3; repeat (4) @(negedge clk);
      cmp_on = 1;
      build(8'h69, 8, 0, 0, 1); rx_send();
      repeat (BIT) @(negedge clk);
      cmp_on = 0;
      chk(rx_valid == 0, "R11 remote rx idle", rx_valid, 0);
      chan_mode = 2'd0; repeat (4) @(negedge clk);

      // R12 modem lines
      rts_on = 1; dtr_on = 1; @(negedge clk);
      chk(rts_n == 0 && dtr_n == 0, "R12 outputs", {rts_n, dtr_n}, 0);
      cts_n = 0; ri_n = 0; @(negedge clk);
      chk(modem_st == 4'b0000, "R12 sync one clock", modem_st, 0);
      @(negedge clk);
      chk(modem_st == 4'b1001, "R12 sync two clocks", modem_st, 4'b1001);

      done = 1;
      summary();
      $finish;
   end
endmodule